// File: doc/BRIEF.md
# Frame memory rectangle mover

This block copies a rectangular region of 16-bit pixels between a 32-bit word port and a frame memory whose rows are 1024 pixels wide. A command framer issues a start pulse carrying a position word, a size word and a direction. The block then walks the rectangle in row order and turns each data word into two single-pixel memory accesses on a synchronous one-pixel memory port.

Data can arrive with gaps of any length. The block keeps its column and row cursor between words, so a burst may stop in the middle of a row and the next word continues at the next pixel. In the read direction the start request also fetches the two pixels at the start position into the read-data register at once. Each later read request fetches the next two pixels of the walk. When the last pixel has been issued, a one-cycle completion pulse reports the rectangle as it was first decoded, so that caches downstream can drop stale lines.

Top module: `vram_rect_xfer`

## Requirements
- R1: The start column is `pos_word[9:0]` and the start row is `pos_word[24:16]`. All other position bits are ignored. `mem_addr` is row×1024+column: bits 18:10 hold the row and bits 9:0 hold the column.
- R2: Width is `((size_word[9:0] − 1) mod 1024) + 1`, so a field of 0 selects 1024 pixels. Bits 15:10 are ignored.
- R3: Height is `((size_word[31:16] − 1) mod 512) + 1`, so a low-nine-bit value of 0 selects 512 rows. Bits 31:25 are ignored.
- R4: In a write, each accepted word produces two pixel writes: bits 15:0 first, then bits 31:16. Pixels are written left to right within a row, and rows are written top to bottom.
- R5: Idle cycles between words have no effect on the order or the addresses of the pixels. A word may begin in the middle of a row, and a word may span two rows.
- R6: The column address wraps modulo 1024 and the row address wraps modulo 512.
- R7: In the cycle after the final pixel access is issued, `done` is high for exactly one cycle, `busy` is low, and `done_x`/`done_y`/`done_w`/`done_h` give the decoded start column, start row, width and height.
- R8: When the pixel count is odd, the upper half of the final word is dropped and no memory access is made for it.
- R9: A read start places {pixel(x+1,y), pixel(x,y)} in `rd_data` within four cycles. This preload does not move the cursor and does not pulse `rd_valid`.
- R10: Each accepted `rd_req` in a read transfer reads the next two pixels. Two cycles after the second memory read, `rd_valid` pulses and `rd_data` holds the earlier pixel in bits 15:0. If the transfer ends on the lower half, bits 31:16 are zero.
- R11: A start while `busy` abandons the old transfer and pulses `anomaly` for one cycle. A start while idle leaves `anomaly` low. The abandoned transfer produces no `done`.
- R12: `wr_valid` during a read transfer, and `rd_req` during a write transfer, are ignored: no memory access, no cursor movement.
- R13: After reset, `busy`, `done`, `anomaly`, `data_ready`, `mem_we` and `rd_valid` are 0 and `rd_data` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin a transfer with the words below |
| start_read | input | 1 | Direction of the new transfer: 1 read, 0 write |
| pos_word | input | 32 | Start position word |
| size_word | input | 32 | Rectangle size word |
| wr_valid | input | 1 | Write-data word offered |
| wr_data | input | 32 | Two pixels, lower half first |
| rd_req | input | 1 | Request the next two pixels |
| data_ready | output | 1 | A word or request can be accepted this cycle |
| rd_data | output | 32 | Read-data register |
| rd_valid | output | 1 | `rd_data` was just updated by a request |
| mem_addr | output | 19 | Pixel address, row×1024+column |
| mem_we | output | 1 | Pixel write strobe |
| mem_wdata | output | 16 | Pixel to write |
| mem_re | output | 1 | Pixel read strobe |
| mem_rdata | input | 16 | Pixel read, valid the cycle after `mem_re` |
| busy | output | 1 | A transfer is in progress |
| done | output | 1 | One-cycle completion pulse |
| anomaly | output | 1 | One-cycle pulse: a start arrived while busy |
| done_x | output | 10 | Decoded start column |
| done_y | output | 9 | Decoded start row |
| done_w | output | 11 | Decoded width, 1 to 1024 |
| done_h | output | 10 | Decoded height, 1 to 512 |

## Verification
The assertions check on every cycle that completion follows a busy period, that `busy` only falls with a completion pulse, that an anomaly appears only while a transfer stays busy, that every `rd_valid` traces back to a memory read two cycles earlier, and that back-to-back pixel writes never hit the same address. Only the bench scenarios can show the address arithmetic: the decode of the masked fields, the 0-means-maximum width and height, column and row wrap, and data order across pauses. They also cover the dropped odd half, the contents of the preload, and the abort-and-restart sequence.

// File: rtl/vram_rect_xfer.sv
module vram_rect_xfer #(
  parameter int XBITS = 10,
  parameter int YBITS = 9
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   start,
  input  logic                   start_read,
  input  logic [31:0]            pos_word,
  input  logic [31:0]            size_word,
  input  logic                   wr_valid,
  input  logic [31:0]            wr_data,
  input  logic                   rd_req,
  output logic                   data_ready,
  output logic [31:0]            rd_data,
  output logic                   rd_valid,
  output logic [XBITS+YBITS-1:0] mem_addr,
  output logic                   mem_we,
  output logic [15:0]            mem_wdata,
  output logic                   mem_re,
  input  logic [15:0]            mem_rdata,
  output logic                   busy,
  output logic                   done,
  output logic                   anomaly,
  output logic [XBITS-1:0]       done_x,
  output logic [YBITS-1:0]       done_y,
  output logic [XBITS:0]         done_w,
  output logic [YBITS:0]         done_h
);
  localparam int WBITS = XBITS + 1;
  localparam int HBITS = YBITS + 1;
  localparam logic [XBITS-1:0] XONE = 1;
  localparam logic [YBITS-1:0] YONE = 1;
  localparam logic [WBITS-1:0] WONE = 1;
  localparam logic [HBITS-1:0] HONE = 1;

  logic             active, is_rd, hi;
  logic [1:0]       ops, pre;
  logic [XBITS-1:0] x0, col;
  logic [YBITS-1:0] y0, cy;
  logic [WBITS-1:0] w;
  logic [HBITS-1:0] h, rows_left;
  logic [31:0]      wlat, rd_q;
  logic             cap_en, cap_hi, cap_vis, cap_last;
  logic             done_q, anom_q, rdv_q;

  logic [XBITS-1:0] new_x, wm1, pre_x;
  logic [YBITS-1:0] new_y, hm1;
  logic [WBITS-1:0] new_w;
  logic [HBITS-1:0] new_h;
  logic             pix_step, row_end, last_px, accept;

  assign new_x = pos_word[XBITS-1:0];
  assign new_y = pos_word[16 +: YBITS];
  assign wm1   = size_word[XBITS-1:0] - XONE;
  assign hm1   = size_word[16 +: YBITS] - YONE;
  assign new_w = {1'b0, wm1} + WONE;
  assign new_h = {1'b0, hm1} + HONE;

  assign pix_step = active && (pre == 2'd0) && (ops != 2'd0);
  assign row_end  = ({1'b0, col} == (w - WONE));
  assign last_px  = row_end && (rows_left == HONE);
  assign pre_x    = x0 + ((pre == 2'd1) ? XONE : '0);

  assign mem_addr  = (pre != 2'd0) ? {y0, pre_x} : {cy, x0 + col};
  assign mem_we    = pix_step && !is_rd;
  assign mem_re    = active && is_rd && ((pre != 2'd0) || (ops != 2'd0));
  assign mem_wdata = hi ? wlat[31:16] : wlat[15:0];

  assign data_ready = active && (ops == 2'd0) && (pre == 2'd0) && !cap_en;
  assign accept     = data_ready && (is_rd ? rd_req : wr_valid);

  assign busy     = active;
  assign done     = done_q;
  assign anomaly  = anom_q;
  assign rd_data  = rd_q;
  assign rd_valid = rdv_q;
  assign done_x   = x0;
  assign done_y   = y0;
  assign done_w   = w;
  assign done_h   = h;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      active <= 1'b0; is_rd <= 1'b0; hi <= 1'b0;
      ops <= '0; pre <= '0;
      x0 <= '0; y0 <= '0; w <= '0; h <= '0;
      col <= '0; cy <= '0; rows_left <= '0; wlat <= '0;
      done_q <= 1'b0; anom_q <= 1'b0;
    end else if (start) begin
      anom_q    <= active;
      done_q    <= 1'b0;
      active    <= 1'b1;
      is_rd     <= start_read;
      x0        <= new_x;
      y0        <= new_y;
      w         <= new_w;
      h         <= new_h;
      col       <= '0;
      cy        <= new_y;
      rows_left <= new_h;
      ops       <= '0;
      hi        <= 1'b0;
      pre       <= start_read ? 2'd2 : 2'd0;
    end else begin
      anom_q <= 1'b0;
      done_q <= 1'b0;
      if (accept) begin
        ops  <= 2'd2;
        hi   <= 1'b0;
        wlat <= wr_data;
      end else if (pix_step) begin
        hi  <= ~hi;
        ops <= ops - 2'd1;
        if (row_end) begin
          col       <= '0;
          cy        <= cy + YONE;
          rows_left <= rows_left - HONE;
        end else begin
          col <= col + XONE;
        end
        if (last_px) begin
          active <= 1'b0;
          ops    <= '0;
          done_q <= 1'b1;
        end
      end else if (active && pre != 2'd0) begin
        pre <= pre - 2'd1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cap_en <= 1'b0; cap_hi <= 1'b0; cap_vis <= 1'b0; cap_last <= 1'b0;
      rd_q <= '0; rdv_q <= 1'b0;
    end else begin
      cap_en   <= mem_re && !start;
      cap_hi   <= (pre != 2'd0) ? (pre == 2'd1) : hi;
      cap_vis  <= (pre == 2'd0);
      cap_last <= (pre == 2'd0) && (hi || last_px);
      rdv_q    <= cap_en && cap_vis && cap_last;
      if (cap_en) begin
        if (cap_hi) rd_q[31:16] <= mem_rdata;
        else        rd_q        <= {16'h0000, mem_rdata};
      end
    end
  end

  assert_done_after_busy_R7: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (!busy && $past(busy)));

  assert_busy_ends_with_done_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> done);

  assert_anomaly_while_busy_R11: assert property (@(posedge clk) disable iff (!rst_n)
    anomaly |-> (busy && $past(busy)));

  assert_rdvalid_from_read_R10: assert property (@(posedge clk) disable iff (!rst_n)
    rd_valid |-> $past(mem_re, 2));

  assert_writes_advance_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_we && $past(mem_we) && !$past(start)) |-> (mem_addr != $past(mem_addr)));
endmodule

// File: tb/test_vram_rect_xfer.sv
module test_vram_rect_xfer;
  localparam int CLK_PERIOD = 10;
  localparam int NT = 7;
  localparam logic [31:0] T_POS  [NT] = '{32'h0003_0005, 32'h000A_0064, 32'h0000_03FE,
                                          32'h01FF_0000, 32'h0004_0000, 32'h0000_0007, 32'hFF05_F403};
  localparam logic [31:0] T_SIZE [NT] = '{32'h0002_0003, 32'h0001_0003, 32'h0001_0004,
                                          32'h0002_0002, 32'h0001_0000, 32'h0000_0001, 32'hFE02_0402};
  localparam int T_WORDS [NT] = '{3, 2, 2, 2, 512, 256, 2};
  localparam int T_WR    [NT] = '{6, 3, 4, 4, 1024, 512, 4};
  localparam int T_X     [NT] = '{5, 100, 1022, 0, 0, 7, 3};
  localparam int T_Y     [NT] = '{3, 10, 0, 511, 4, 0, 261};
  localparam int T_W     [NT] = '{3, 3, 4, 2, 1024, 1, 2};
  localparam int T_H     [NT] = '{2, 1, 1, 2, 1, 512, 2};
  localparam int T_FIRST [NT] = '{3077, 10340, 1022, 523264, 4096, 7, 267267};
  localparam int T_LAST  [NT] = '{4103, 10342, 1, 1, 5119, 523271, 268292};

  logic clk = 0, rst_n = 0;
  logic start = 0, start_read = 0, wr_valid = 0, rd_req = 0;
  logic [31:0] pos_word = 0, size_word = 0, wr_data = 0;
  logic data_ready, rd_valid, mem_we, mem_re, busy, done, anomaly;
  logic [31:0] rd_data;
  logic [18:0] mem_addr;
  logic [15:0] mem_wdata, mem_rdata = 0;
  logic [9:0] done_x; logic [8:0] done_y; logic [10:0] done_w; logic [9:0] done_h;

  vram_rect_xfer i_vram_rect_xfer (
    .clk(clk), .rst_n(rst_n), .start(start), .start_read(start_read),
    .pos_word(pos_word), .size_word(size_word), .wr_valid(wr_valid), .wr_data(wr_data),
    .rd_req(rd_req), .data_ready(data_ready), .rd_data(rd_data), .rd_valid(rd_valid),
    .mem_addr(mem_addr), .mem_we(mem_we), .mem_wdata(mem_wdata), .mem_re(mem_re),
    .mem_rdata(mem_rdata), .busy(busy), .done(done), .anomaly(anomaly),
    .done_x(done_x), .done_y(done_y), .done_w(done_w), .done_h(done_h));

  always #(CLK_PERIOD/2) clk = ~clk;

  function automatic logic [15:0] pix(input logic [18:0] a);
    return a[15:0] ^ 16'h5A5A;
  endfunction
  always @(posedge clk) if (mem_re) mem_rdata <= pix(mem_addr);

  int checks = 0, failures = 0, cyc = 0;
  bit finished = 0;
  int m_x0, m_y0, m_w, m_base;
  int w_cnt, mism, done_cnt, anom_cnt, rdv_cnt;
  int first_a, last_a, dx, dy, dw, dh;

  always @(negedge clk) if (rst_n) begin
    if (mem_we) begin
      automatic int row = w_cnt / m_w;
      automatic int cl = w_cnt % m_w;
      automatic int ea = ((m_y0 + row) % 512) * 1024 + ((m_x0 + cl) % 1024);
      if (int'(mem_addr) != ea || mem_wdata !== 16'(m_base + w_cnt)) mism++;
      if (w_cnt == 0) first_a = int'(mem_addr);
      last_a = int'(mem_addr);
      w_cnt++;
    end
    if (done) begin
      done_cnt++; dx = done_x; dy = done_y; dw = done_w; dh = done_h;
    end
    if (anomaly) anom_cnt++;
    if (rd_valid) rdv_cnt++;
  end

  task automatic summary();
    if (!finished) begin
      finished = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000 && !finished) begin
      failures++;
      $display("FAIL R7 watchdog expired actual=%0d expected=<150000", cyc);
      summary();
    end
  end

  task automatic check_eq(input string req, input longint act, input longint exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic model(input int x, input int y, input int wd, input int base);
    m_x0 = x; m_y0 = y; m_w = wd; m_base = base;
    w_cnt = 0; mism = 0; done_cnt = 0; rdv_cnt = 0;
  endtask

  task automatic go(input logic [31:0] p, input logic [31:0] s, input logic rd);
    pos_word = p; size_word = s; start_read = rd; start = 1;
    @(negedge clk);
    start = 0;
  endtask

  task automatic feed(input int k, input int base);
    while (!data_ready) @(negedge clk);
    wr_data = {16'(base + 2*k + 1), 16'(base + 2*k)};
    wr_valid = 1;
    @(negedge clk);
    wr_valid = 0;
    repeat (k % 3) @(negedge clk);
  endtask

  task automatic request();
    while (!data_ready) @(negedge clk);
    rd_req = 1;
    @(negedge clk);
    rd_req = 0;
  endtask

  initial begin
    m_w = 1; anom_cnt = 0;
    model(0, 0, 1, 0);
    repeat (3) @(negedge clk);
    // R13 reset state
    check_eq("R13 busy", busy, 0);
    check_eq("R13 done", done, 0);
    check_eq("R13 data_ready", data_ready, 0);
    check_eq("R13 mem_we", mem_we, 0);
    check_eq("R13 rd_data", rd_data, 0);
    check_eq("R13 rd_valid", rd_valid, 0);
    rst_n = 1;
    @(negedge clk);

    for (int t = 0; t < NT; t++) begin
      model(T_X[t], T_Y[t], T_W[t], 16'h1000 * (t + 1));
      go(T_POS[t], T_SIZE[t], 1'b0);
      for (int k = 0; k < T_WORDS[t]; k++) feed(k, m_base);
      repeat (4) @(negedge clk);
      check_eq("R2 R3 R8 write count", w_cnt, T_WR[t]);
      check_eq("R1 first address", first_a, T_FIRST[t]);
      check_eq("R6 last address", last_a, T_LAST[t]);
      check_eq("R4 R5 pixel order and data", mism, 0);
      check_eq("R7 done pulses", done_cnt, 1);
      check_eq("R7 rect x/y", dx * 1024 + dy, T_X[t] * 1024 + T_Y[t]);
      check_eq("R7 rect w/h", dw * 1024 + dh, T_W[t] * 1024 + T_H[t]);
      check_eq("R7 busy low", busy, 0);
    end
    check_eq("R11 no anomaly when idle", anom_cnt, 0);

    // R9 R10 R12 read transfer: x=10 y=2 w=3 h=1
    model(10, 2, 3, 0);
    go(32'h0002_000A, 32'h0001_0003, 1'b1);
    repeat (4) @(negedge clk);
    check_eq("R9 preload data", rd_data, {pix(19'd2059), pix(19'd2058)});
    check_eq("R9 preload no rd_valid", rdv_cnt, 0);
    wr_data = 32'hDEAD_BEEF; wr_valid = 1;
    @(negedge clk);
    wr_valid = 0;
    repeat (3) @(negedge clk);
    check_eq("R12 wr_valid ignored in read", w_cnt, 0);
    check_eq("R12 still ready", data_ready, 1);
    request();
    for (int i = 0; i < 10 && rdv_cnt < 1; i++) @(negedge clk);
    check_eq("R10 first word", rd_data, {pix(19'd2059), pix(19'd2058)});
    request();
    for (int i = 0; i < 10 && rdv_cnt < 2; i++) @(negedge clk);
    check_eq("R10 odd tail word", rd_data, {16'h0000, pix(19'd2060)});
    check_eq("R7 read done", done_cnt, 1);
    check_eq("R7 read rect", dx * 1024 + dy * 16 + dw, 10 * 1024 + 2 * 16 + 3);

    // R12 rd_req in a write transfer
    model(0, 5, 2, 16'h6000);
    go(32'h0005_0000, 32'h0001_0002, 1'b0);
    rd_req = 1;
    repeat (3) @(negedge clk);
    rd_req = 0;
    check_eq("R12 rd_req ignored in write", rdv_cnt + w_cnt, 0);
    feed(0, m_base);
    repeat (4) @(negedge clk);
    check_eq("R12 write intact", mism * 100 + w_cnt, 2);

    // R11 restart while busy
    anom_cnt = 0;
    model(0, 0, 4, 16'h7000);
    go(32'h0000_0000, 32'h0001_0004, 1'b0);
    feed(0, m_base);
    repeat (4) @(negedge clk);
    model(50, 1, 2, 16'h8000);
    go(32'h0001_0032, 32'h0001_0002, 1'b0);
    @(negedge clk);
    check_eq("R11 anomaly one cycle", anom_cnt, 1);
    feed(0, m_base);
    repeat (4) @(negedge clk);
    check_eq("R11 new transfer writes", w_cnt, 2);
    check_eq("R11 new transfer order", mism, 0);
    check_eq("R11 first address", first_a, 1074);
    check_eq("R11 single done", done_cnt, 1);
    check_eq("R11 done rect", dx * 1024 + dy * 16 + dw, 50 * 1024 + 16 + 2);

    summary();
  end
endmodule